// File: doc/BRIEF.md
# Bypassing Carry-Save Array Multiplier

This block multiplies two unsigned operands and returns the exact double-width product. Every partial-product bit `a[i] & b[j]` is formed in parallel. The rows are reduced through a regular grid of carry-save cells. A ripple adder in the final row resolves the last sum and carry vectors into the upper product bits. The low product bits drop out of the grid's right edge, one per row.

Each grid cell has a bypass path. When the cell's partial-product bit is zero, the cell does not perform a three-input addition. It only merges the sum and carry that arrive from the row above, which gives exactly the result a full adder would give with a zero addend. Operands with many zero bits therefore leave most of the grid in its cheaper forwarding path. The arithmetic result does not change.

A parameter can wrap the combinational core in input and output registers for timing work. In that case a new operand pair is accepted on every clock.

Top module: `csa_bypass_mul`

## Requirements
- R1: `p_o` equals the exact unsigned product `a * b`, `A_W + B_W` bits wide, for every operand pair.
- R2: With `REG_IO = 1` (default), the product of the operands present at one rising edge appears on `p_o` after the next rising edge. That is a latency of two edges.
- R3: While `rst_ni` is low, and after any reset assertion, `p_o` reads 0 whatever the operands are. Reset is asynchronous and active low.
- R4: If either operand is all zeros, the product is 0. In this case every cell of the grid takes its bypass path.
- R5: All-ones operands give `(2^A_W - 1) * (2^B_W - 1)`.
- R6: A single set bit at position k in one operand (bit 0 being the LSB) gives the other operand shifted left by k.
- R7: The carry out of the final ripple adder is never set, so no product bit is lost.
- R8: A bypassed cell yields the same sum and carry as a full adder with a zero addend. Sparse operands, where most cells bypass while carries are still in flight, give exact products.
- R9: Operand pairs applied on consecutive cycles produce their products on consecutive cycles, in order, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional wrapper registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | A_W | Multiplicand, unsigned |
| b_i | input | B_W | Multiplier, unsigned |
| p_o | output | A_W+B_W | Unsigned product |

## Verification
The bench applies zero operands, so that the whole grid bypasses. It applies all-ones operands, so that no cell bypasses and the carry chains are at their longest. Single-bit operands expose a misrouted row or column as a wrong shift. Sparse operands mix bypassed cells with live carries, which is where a wrong bypass carry would show. Random pairs streamed back to back check exactness and the two-edge pipeline order against a shift-and-add reference.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
  typedef struct packed {
    logic s;
    logic c;
  } cs_bit_t;
endpackage

// File: rtl/csa_byp_cell.sv
module csa_byp_cell
  import csa_mul_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  cs_bit_t in_i,
  output cs_bit_t out_o
);
  logic pp;
  assign pp = a_i & b_i;

  // zero addend: merge incoming sum/carry only, no three-input add
  always_comb begin
    if (pp) begin
      out_o.s = pp ^ in_i.s ^ in_i.c;
      out_o.c = (pp & in_i.s) | (pp & in_i.c) | (in_i.s & in_i.c);
    end else begin
      out_o.s = in_i.s ^ in_i.c;
      out_o.c = in_i.s & in_i.c;
    end
  end
endmodule

// File: rtl/csa_grid.sv
module csa_grid
  import csa_mul_pkg::*;
#(
  parameter int unsigned M = 16,
  parameter int unsigned N = 16
) (
  input  logic [M-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] lo_o,
  output logic [M-1:0] sum_o,
  output logic [M-1:0] car_o
);
  // grid[j][i]: s weight 2^(i+j), c weight 2^(i+j+1)
  cs_bit_t grid [N][M];

  for (genvar i = 0; i < M; i++) begin : g_row0
    assign grid[0][i] = '{s: a_i[i] & b_i[0], c: 1'b0};
  end

  for (genvar j = 1; j < N; j++) begin : g_row
    for (genvar i = 0; i < M; i++) begin : g_col
      cs_bit_t cin;
      if (i == M - 1) begin : g_edge
        assign cin = '{s: 1'b0, c: grid[j-1][i].c};
      end else begin : g_inner
        assign cin = '{s: grid[j-1][i+1].s, c: grid[j-1][i].c};
      end
      csa_byp_cell u_cell (
        .a_i  (a_i[i]),
        .b_i  (b_i[j]),
        .in_i (cin),
        .out_o(grid[j][i])
      );
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_lo
    assign lo_o[j] = grid[j][0].s;
  end

  for (genvar i = 0; i < M; i++) begin : g_out
    if (i == M - 1) begin : g_top
      assign sum_o[i] = 1'b0;
    end else begin : g_mid
      assign sum_o[i] = grid[N-1][i+1].s;
    end
    assign car_o[i] = grid[N-1][i].c;
  end
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign sum_o[k] = x_i[k] ^ y_i[k] ^ cy[k];
    assign cy[k+1]  = (x_i[k] & y_i[k]) | (cy[k] & (x_i[k] ^ y_i[k]));
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/csa_bypass_mul.sv
module csa_bypass_mul #(
  parameter int unsigned A_W    = 16,
  parameter int unsigned B_W    = 16,
  parameter bit          REG_IO = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-1:0] p_o
);
  localparam int unsigned P_W = A_W + B_W;

  logic [A_W-1:0] core_a;
  logic [B_W-1:0] core_b;
  logic [B_W-1:0] lo;
  logic [A_W-1:0] sum_v, car_v, hi;
  logic           rca_cout;
  logic [P_W-1:0] core_p;

  csa_grid #(.M(A_W), .N(B_W)) u_grid (
    .a_i  (core_a),
    .b_i  (core_b),
    .lo_o (lo),
    .sum_o(sum_v),
    .car_o(car_v)
  );

  csa_ripple #(.W(A_W)) u_rca (
    .x_i   (sum_v),
    .y_i   (car_v),
    .sum_o (hi),
    .cout_o(rca_cout)
  );

  assign core_p = {hi, lo};

  if (REG_IO) begin : g_reg
    logic [1:0] warm;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        core_a <= '0;
        core_b <= '0;
        p_o    <= '0;
        warm   <= '0;
      end else begin
        core_a <= a_i;
        core_b <= b_i;
        p_o    <= core_p;
        if (warm != 2'd2) warm <= warm + 2'd1;
      end
    end

    // R1
    core_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_p == P_W'(core_a) * P_W'(core_b));

    // R7
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rca_cout);

    // R2
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm == 2'd2) |-> p_o == P_W'($past(a_i, 2)) * P_W'($past(b_i, 2)));

    // R4
    zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_a == '0 || core_b == '0) |=> p_o == '0);
  end else begin : g_comb
    assign core_a = a_i;
    assign core_b = b_i;
    assign p_o    = core_p;
  end
endmodule

// File: tb/sim_csa_bypass_mul.sv
module sim_csa_bypass_mul;
  localparam int AW    = 16;
  localparam int BW    = 16;
  localparam int PW    = AW + BW;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] a_r = '0;
  logic [BW-1:0] b_r = '0;
  logic [PW-1:0] p_o;

  int checks = 0;
  int fails  = 0;

  bit            v0 = 0, v1 = 0;
  logic [PW-1:0] e0 = '0, e1 = '0;
  string         t0 = "", t1 = "";

  always #(CLK_P/2) clk = ~clk;

  csa_bypass_mul #(.A_W(AW), .B_W(BW), .REG_IO(1'b1)) u0 (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .a_i   (a_r),
    .b_i   (b_r),
    .p_o   (p_o)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [AW-1:0] a, input logic [BW-1:0] b);
    logic [PW-1:0] acc = '0;
    for (int k = 0; k < BW; k++)
      if (b[k]) acc = acc + (PW'(a) << k);
    return acc;
  endfunction

  task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: p_o=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one pair per cycle; check the pair driven two cycles earlier
  task automatic step(input logic [AW-1:0] a, input logic [BW-1:0] b, input bit vld, input string tag);
    @(negedge clk);
    if (v1) check(p_o, e1, t1);
    v1 = v0; e1 = e0; t1 = t0;
    v0 = vld; e0 = ref_mul(a, b); t0 = tag;
    a_r = a; b_r = b;
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    a_r = 16'hbeef; b_r = 16'h1234;
    repeat (3) @(negedge clk);
    check(p_o, '0, "R3 in reset");
    @(negedge clk) rst_ni = 1'b1;

    step('0, '0, 1, "R4 zero*zero");
    step('0, '1, 1, "R4 zero*ones");
    step('1, '0, 1, "R4 ones*zero");
    step('1, '1, 1, "R5 ones*ones");
    step('1, '1, 1, "R5 repeat");
    for (int k = 0; k < BW; k++) step(16'ha5c3, BW'(1) << k, 1, "R6 single bit b");
    for (int k = 0; k < AW; k++) step(AW'(1) << k, 16'hffff, 1, "R6 single bit a");
    step(16'h8001, 16'h8001, 1, "R8 sparse ends");
    step(16'h1010, 16'h0101, 1, "R8 sparse mid");
    step(16'h8000, 16'h8000, 1, "R7 msb*msb");
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a = AW'($urandom & $urandom & $urandom);
      logic [BW-1:0] b = BW'($urandom & $urandom & $urandom);
      step(a, b, 1, "R8 sparse random");
    end
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [BW-1:0] b = BW'($urandom);
      step(a, b, 1, (k % 2) ? "R9 back-to-back" : "R1 random");
    end
    for (int k = 0; k < 20; k++) step(AW'(k * 3277), '1, 1, "R2 pipeline walk");
    step('0, '0, 0, "");
    step('0, '0, 0, "");

    a_r = 16'hffff; b_r = 16'hffff;
    @(negedge clk);
    check(p_o, '0, "R3 hold zero");
    @(negedge clk) rst_ni = 1'b0;
    #1 check(p_o, '0, "R3 async reset");
    @(negedge clk);
    check(p_o, '0, "R3 during reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule